// File: doc/BRIEF.md
# Serial Port Interrupt Status Logic

This block turns the state of a serial port's receive and transmit FIFOs, plus a few event pulses from the serial engine, into four interrupt conditions and one combined interrupt line. Two of the conditions are level conditions and follow the FIFO fill levels directly. The receive side is "at least half full" and the transmit side is "at least half empty". The other two are sticky events. An overrun is recorded when a frame completes while the receive FIFO is already full. A receive timeout is recorded when data has sat unread in the receive FIFO for a fixed number of bit periods.

Software sees the conditions through a small register port with four word offsets. Offset 0 is the read-write mask. Offset 1 is raw status. Offset 2 is raw status ANDed with the mask. Offset 3 is a write-one-to-clear register for the two sticky conditions. Reads are combinational and writes take effect at the clock edge. The FIFOs and the serial engine live elsewhere and feed this block only plain status and single-cycle pulses, so no stream handshake is involved.

Top module: `sp_irq_status`

## Requirements
- R1: Overrun (bit 0) becomes 1 the cycle after `frame_rcvd` is high while `rx_full` is high, and then stays 1 until it is cleared.
- R2: Timeout (bit 1) becomes 1 the cycle after the TMO_BITS-th `bit_tick` (32 by default) counted while the receive FIFO is non-empty. The count restarts on `rx_read` or `frame_rcvd`, is held at zero while `rx_empty` is high, and fires only once per unread stretch.
- R3: Receive level (bit 2) reads 1 exactly when `rx_level` >= FIFO_DEPTH/2.
- R4: Transmit level (bit 3) reads 1 exactly when `tx_level` <= FIFO_DEPTH/2, meaning at least half of the FIFO is free.
- R5: The mask at offset 0 resets to 0. A write updates it on the next edge, and a read returns it.
- R6: Offset 2 reads the bitwise AND of raw status and the mask.
- R7: A write to offset 3 clears overrun where wdata bit 0 is 1 and timeout where wdata bit 1 is 1. Zero bits have no effect, and offset 3 reads as 0.
- R8: If a set event and a clear of the same bit occur in the same cycle, the bit is left set.
- R9: `irq` is the OR of the four masked bits.
- R10: Raw status is read at offset 1 with overrun at bit 0, timeout at bit 1, receive level at bit 2 and transmit level at bit 3. The mask and masked registers use the same bit order.
- R11: After reset both sticky bits are 0 and `irq` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_level | input | LVL_W | Receive FIFO fill count |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_full | input | 1 | Receive FIFO full |
| tx_level | input | LVL_W | Transmit FIFO fill count |
| frame_rcvd | input | 1 | One-cycle pulse when a frame completes |
| rx_read | input | 1 | One-cycle pulse when the receive FIFO is popped |
| bit_tick | input | 1 | One-cycle pulse per serial bit period |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word offset |
| reg_wdata | input | 4 | Register write data |
| reg_rdata | output | 4 | Register read data (combinational) |
| irq | output | 1 | Combined interrupt |

## Verification
The hardest state to reach from the ports is the timeout boundary. The receive FIFO must stay non-empty and unread for exactly 31 and then 32 ticks, and random pulses almost never leave it alone that long. Directed sequences therefore hold the FIFO non-empty with no reads and count ticks precisely. They show that an empty interval or an incoming frame restarts the count, and that the event does not fire again once cleared. A second directed case collides an overrun with its clear in the same cycle. Randomized traffic, with rare reads and frequent ticks, then covers everything against a cycle model kept in the bench.

// File: rtl/sp_irq_pkg.sv
package sp_irq_pkg;
  localparam int NUM_IRQ    = 4;
  localparam int NUM_STICKY = 2;
  localparam int OFS_W      = 2;

  localparam int IDX_OVR = 0;
  localparam int IDX_TMO = 1;
  localparam int IDX_RXL = 2;
  localparam int IDX_TXL = 3;

  typedef enum logic [OFS_W-1:0] {
    OFS_MASK   = 2'd0,
    OFS_RAW    = 2'd1,
    OFS_MASKED = 2'd2,
    OFS_CLEAR  = 2'd3
  } reg_ofs_e;
endpackage

// File: rtl/sp_irq_rx_timer.sv
module sp_irq_rx_timer #(
  parameter int TMO_BITS = 32
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rx_empty,
  input  logic restart,
  input  logic bit_tick,
  output logic tmo_evt
);
  localparam int CNT_W = $clog2(TMO_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_TOP  = CNT_W'(TMO_BITS);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_BITS - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             advance;

  // Counting saturates at the top so that a cleared timeout stays quiet
  // until the next read, frame or empty interval.
  assign advance = !rx_empty && !restart && bit_tick && (cnt_q != CNT_TOP);
  assign tmo_evt = advance && (cnt_q == CNT_LAST);

  always_comb begin
    cnt_d = cnt_q;
    if (rx_empty || restart) cnt_d = '0;
    else if (advance)        cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/sp_irq_sticky.sv
module sp_irq_sticky #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_evt,
  input  logic [N-1:0] clr_req,
  output logic [N-1:0] flag_q
);
  generate
    for (genvar i = 0; i < N; i++) begin : g_flag
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          flag_q[i] <= 1'b0;
        else if (set_evt[i]) flag_q[i] <= 1'b1;
        else if (clr_req[i]) flag_q[i] <= 1'b0;
      end
    end
  endgenerate
endmodule

// File: rtl/sp_irq_regfile.sv
module sp_irq_regfile
  import sp_irq_pkg::*;
(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  reg_wr,
  input  logic [OFS_W-1:0]      reg_addr,
  input  logic [NUM_IRQ-1:0]    reg_wdata,
  input  logic [NUM_IRQ-1:0]    raw,
  output logic [NUM_IRQ-1:0]    reg_rdata,
  output logic [NUM_IRQ-1:0]    mask_q,
  output logic [NUM_STICKY-1:0] clr_req
);
  reg_ofs_e ofs;
  assign ofs = reg_ofs_e'(reg_addr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          mask_q <= '0;
    else if (reg_wr && ofs == OFS_MASK)  mask_q <= reg_wdata;
  end

  assign clr_req = (reg_wr && ofs == OFS_CLEAR) ? reg_wdata[NUM_STICKY-1:0] : '0;

  always_comb begin
    unique case (ofs)
      OFS_MASK:   reg_rdata = mask_q;
      OFS_RAW:    reg_rdata = raw;
      OFS_MASKED: reg_rdata = raw & mask_q;
      default:    reg_rdata = '0;
    endcase
  end
endmodule

// File: rtl/sp_irq_status.sv
module sp_irq_status
  import sp_irq_pkg::*;
#(
  parameter int FIFO_DEPTH = 8,
  parameter int TMO_BITS   = 32,
  localparam int LVL_W     = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [LVL_W-1:0]   rx_level,
  input  logic               rx_empty,
  input  logic               rx_full,
  input  logic [LVL_W-1:0]   tx_level,
  input  logic               frame_rcvd,
  input  logic               rx_read,
  input  logic               bit_tick,
  input  logic               reg_wr,
  input  logic [OFS_W-1:0]   reg_addr,
  input  logic [NUM_IRQ-1:0] reg_wdata,
  output logic [NUM_IRQ-1:0] reg_rdata,
  output logic               irq
);
  localparam logic [LVL_W-1:0] HALF = LVL_W'(FIFO_DEPTH / 2);

  logic                  tmo_evt;
  logic                  ovr_evt;
  logic [NUM_STICKY-1:0] set_w;
  logic [NUM_STICKY-1:0] clr_w;
  logic [NUM_STICKY-1:0] stk_q;
  logic [NUM_IRQ-1:0]    raw_w;
  logic [NUM_IRQ-1:0]    mask_w;

  assign ovr_evt = frame_rcvd && rx_full;

  sp_irq_rx_timer #(.TMO_BITS(TMO_BITS)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_empty (rx_empty),
    .restart  (rx_read || frame_rcvd),
    .bit_tick (bit_tick),
    .tmo_evt  (tmo_evt)
  );

  always_comb begin
    set_w          = '0;
    set_w[IDX_OVR] = ovr_evt;
    set_w[IDX_TMO] = tmo_evt;
  end

  sp_irq_sticky #(.N(NUM_STICKY)) u_sticky (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (set_w),
    .clr_req (clr_w),
    .flag_q  (stk_q)
  );

  always_comb begin
    raw_w          = '0;
    raw_w[IDX_OVR] = stk_q[IDX_OVR];
    raw_w[IDX_TMO] = stk_q[IDX_TMO];
    raw_w[IDX_RXL] = (rx_level >= HALF);
    raw_w[IDX_TXL] = (tx_level <= HALF);
  end

  sp_irq_regfile u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .raw       (raw_w),
    .reg_rdata (reg_rdata),
    .mask_q    (mask_w),
    .clr_req   (clr_w)
  );

  assign irq = |(raw_w & mask_w);
endmodule

// File: rtl/sp_irq_status_chk.sv
module sp_irq_status_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       frame_rcvd,
  input logic       rx_full,
  input logic       bit_tick,
  input logic       reg_wr,
  input logic [1:0] reg_addr,
  input logic [3:0] reg_wdata,
  input logic [3:0] raw,
  input logic [3:0] mask,
  input logic       irq
);
  logic clr_ovr, clr_tmo;
  assign clr_ovr = reg_wr && reg_addr == 2'd3 && reg_wdata[0];
  assign clr_tmo = reg_wr && reg_addr == 2'd3 && reg_wdata[1];

  // R1
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rcvd && rx_full |=> raw[0]);

  // R1
  ovr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    raw[0] && !clr_ovr |=> raw[0]);

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_rcvd && rx_full && clr_ovr |=> raw[0]);

  // R2
  tmo_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !raw[1] && !bit_tick |=> !raw[1]);

  // R7
  clr_tmo_chk: assert property (@(posedge clk) disable iff (!rst_n)
    clr_tmo && !bit_tick |=> !raw[1]);

  // R5
  mask_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 2'd0 |=> mask == $past(reg_wdata));

  // R9
  irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mask == 4'd0 |-> !irq);
endmodule

bind sp_irq_status sp_irq_status_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .frame_rcvd (frame_rcvd),
  .rx_full    (rx_full),
  .bit_tick   (bit_tick),
  .reg_wr     (reg_wr),
  .reg_addr   (reg_addr),
  .reg_wdata  (reg_wdata),
  .raw        (raw_w),
  .mask       (mask_w),
  .irq        (irq)
);

// File: tb/tb_sp_irq_status.sv
module tb_sp_irq_status;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int TMO        = 32;
  localparam int HALF       = DEPTH / 2;
  localparam int LVL_W      = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic [LVL_W-1:0] rx_level = '0;
  logic             rx_empty = 1'b1;
  logic             rx_full = 1'b0;
  logic [LVL_W-1:0] tx_level = '0;
  logic             frame_rcvd = 1'b0;
  logic             rx_read = 1'b0;
  logic             bit_tick = 1'b0;
  logic             reg_wr = 1'b0;
  logic [1:0]       reg_addr = '0;
  logic [3:0]       reg_wdata = '0;
  logic [3:0]       reg_rdata;
  logic             irq;

  int  n_cmp = 0;
  int  n_bad = 0;
  bit  done = 0;

  logic       m_ovr, m_tmo;
  logic [3:0] m_mask;
  int         m_cnt;

  always #(CLK_PERIOD/2) clk = ~clk;

  sp_irq_status #(.FIFO_DEPTH(DEPTH), .TMO_BITS(TMO)) dut (.*);

  function automatic logic [3:0] exp_raw();
    return {(int'(tx_level) <= HALF), (int'(rx_level) >= HALF), m_tmo, m_ovr};
  endfunction

  function automatic logic [3:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0:    return m_mask;
      2'd1:    return exp_raw();
      2'd2:    return exp_raw() & m_mask;
      default: return 4'd0;
    endcase
  endfunction

  task automatic check(string tag, logic [3:0] act, logic [3:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic set_rx(int lvl);
    rx_level = LVL_W'(lvl);
    rx_empty = (lvl == 0);
    rx_full  = (lvl == DEPTH);
  endtask

  // Called just after a negedge with inputs driven: check, clock, update model.
  task automatic cycle();
    logic clr0, clr1, evt, ovr_n, tmo_n;
    string tag;
    #1;
    case (reg_addr)
      2'd0: tag = "R5 mask read";
      2'd1: tag = "R10 raw read";
      2'd2: tag = "R6 masked read";
      default: tag = "R7 clear reads zero";
    endcase
    check(tag, reg_rdata, exp_rd(reg_addr));
    check("R9 irq", {3'b0, irq}, {3'b0, |(exp_raw() & m_mask)});
    clr0 = reg_wr && reg_addr == 2'd3 && reg_wdata[0];
    clr1 = reg_wr && reg_addr == 2'd3 && reg_wdata[1];
    evt = 1'b0;
    if (rx_empty || rx_read || frame_rcvd) m_cnt = 0;
    else if (bit_tick && m_cnt < TMO) begin
      evt = (m_cnt == TMO - 1);
      m_cnt++;
    end
    ovr_n = (m_ovr & ~clr0) | (frame_rcvd & rx_full);
    tmo_n = (m_tmo & ~clr1) | evt;
    @(posedge clk);
    m_ovr = ovr_n;
    m_tmo = tmo_n;
    if (reg_wr && reg_addr == 2'd0) m_mask = reg_wdata;
    @(negedge clk);
    frame_rcvd = 0; rx_read = 0; bit_tick = 0; reg_wr = 0;
  endtask

  task automatic ticks(int n);
    for (int i = 0; i < n; i++) begin
      bit_tick = 1;
      cycle();
    end
  endtask

  task automatic peek(logic [1:0] a, int b, logic v, string tag);
    reg_addr = a;
    #1;
    check(tag, {3'b0, reg_rdata[b]}, {3'b0, v});
  endtask

  task automatic wr(logic [1:0] a, logic [3:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    cycle();
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog expired: actual hung expected finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    m_ovr = 0; m_tmo = 0; m_mask = 0; m_cnt = 0;
    set_rx(0); tx_level = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R11 / R5: reset state
    peek(2'd0, 0, 1'b0, "R5 mask reset");
    reg_addr = 2'd1; #1;
    check("R11 raw after reset", reg_rdata, 4'b1000);
    check("R11 irq after reset", {3'b0, irq}, 4'd0);

    // R1: overrun on frame while full, sticky
    set_rx(DEPTH); frame_rcvd = 1; cycle();
    set_rx(DEPTH - 1); cycle(); cycle();
    peek(2'd1, 0, 1'b1, "R1 overrun sticky");
    // R7: zero write leaves it
    wr(2'd3, 4'b0000);
    peek(2'd1, 0, 1'b1, "R7 zero clear no effect");
    // R8: set and clear in same cycle
    set_rx(DEPTH); frame_rcvd = 1; reg_wr = 1; reg_addr = 2'd3; reg_wdata = 4'b0001; cycle();
    peek(2'd1, 0, 1'b1, "R8 set wins over clear");
    wr(2'd3, 4'b0001);
    peek(2'd1, 0, 1'b0, "R7 clear overrun");

    // R2: timeout exactly at 32 ticks
    set_rx(3); rx_read = 1; cycle();
    ticks(TMO - 1);
    peek(2'd1, 1, 1'b0, "R2 no timeout at 31 ticks");
    ticks(1);
    peek(2'd1, 1, 1'b1, "R2 timeout at 32 ticks");
    wr(2'd3, 4'b0010);
    ticks(40);
    peek(2'd1, 1, 1'b0, "R2 no refire after clear");
    // R2: empty holds count at zero
    set_rx(0); ticks(10);
    set_rx(2); ticks(TMO - 1);
    peek(2'd1, 1, 1'b0, "R2 count restarted by empty");
    ticks(1);
    peek(2'd1, 1, 1'b1, "R2 timeout after empty restart");
    wr(2'd3, 4'b0010);
    // R2: frame restarts count
    rx_read = 1; cycle();
    ticks(20); frame_rcvd = 1; cycle(); ticks(TMO - 1);
    peek(2'd1, 1, 1'b0, "R2 frame restarts count");
    ticks(1);
    peek(2'd1, 1, 1'b1, "R2 timeout after frame restart");

    // R3 / R4 boundaries, R6 / R9 with mask
    wr(2'd0, 4'b1111);
    set_rx(HALF);     peek(2'd1, 2, 1'b1, "R3 rx at half");
    set_rx(HALF - 1); peek(2'd1, 2, 1'b0, "R3 rx below half");
    tx_level = LVL_W'(HALF);     peek(2'd1, 3, 1'b1, "R4 tx at half");
    tx_level = LVL_W'(HALF + 1); peek(2'd1, 3, 1'b0, "R4 tx above half");
    wr(2'd0, 4'b0010);
    peek(2'd2, 1, 1'b1, "R6 masked timeout");
    #1; check("R9 irq from timeout", {3'b0, irq}, 4'd1);
    wr(2'd3, 4'b0010);
    #1; check("R9 irq dropped after clear", {3'b0, irq}, 4'd0);

    // Random traffic
    for (int i = 0; i < 3000; i++) begin
      set_rx($urandom_range(0, DEPTH));
      tx_level   = LVL_W'($urandom_range(0, DEPTH));
      frame_rcvd = ($urandom_range(0, 15) == 0);
      rx_read    = ($urandom_range(0, 40) == 0);
      bit_tick   = ($urandom_range(0, 1) == 0);
      reg_addr   = 2'($urandom_range(0, 3));
      reg_wr     = ($urandom_range(0, 7) == 0);
      reg_wdata  = 4'($urandom_range(0, 15));
      if (i % 200 < 100 && rx_level == 0) set_rx(1);
      cycle();
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule